// File: doc/BRIEF.md
# S1 Record Line Parser

This block reads a text stream of hexadecimal load records, one character for each cycle in which `in_valid` is high, and turns each S1 record into a series of byte writes. A record starts with `S` and the type digit `1`. Two hex characters then give the byte count, four give the 16-bit load address, and the data bytes and a checksum byte follow, each as a pair of hex characters. Each data byte is issued on the write port as soon as its second character is accepted. The first data byte goes to the load address and each later byte goes to the next higher address.

The block keeps a modulo-256 sum of every byte after the type digit. After the checksum byte it pulses `rec_done` together with either `chk_ok` or `chk_err`. The writes have already left the block by then, so the consumer holds them until the verdict arrives and then commits or drops them. A record with a type other than S1 raises `unsup_type` and is skipped. A malformed record raises `fmt_err`. In both cases the parser ignores input until the line ends.

Top module: `srec_line_parser`

## Requirements
- R1: Each data byte of an S1 record produces one cycle of `wr_en` with `wr_data` equal to that byte. The first data byte is written at the record's load address (most significant address byte first in the text) and each following byte at the previous address plus one, wrapping modulo 2^16.
- R2: The number of data bytes is the count byte minus 3. A count of exactly 3 produces no write and still ends with a verdict.
- R3: When the sum modulo 256 of the count, address, data and checksum bytes equals 0xFF, `rec_done` and `chk_ok` pulse high together for one cycle, with `chk_err` low.
- R4: When that sum is not 0xFF, `rec_done` and `chk_err` pulse high together for one cycle, with `chk_ok` low. Writes already issued for the record are not withdrawn.
- R5: If the character after `S` is not `1`, `unsup_type` pulses for one cycle. No write or verdict follows, and input is ignored until CR (0x0D) or LF (0x0A). If that character is itself CR or LF, the parser returns to the idle state at once.
- R6: A character that is not a hex digit anywhere between the type digit and the end of the checksum pulses `fmt_err` for one cycle. The record ends without a verdict and input is skipped to CR or LF; a CR or LF as the offending character returns to idle at once.
- R7: A count byte below 3 pulses `fmt_err` right after the count byte and skips the rest of the line.
- R8: Outside a record, any character other than `S` is ignored. A character presented while `in_valid` is low has no effect anywhere.
- R9: Hex digits are accepted in upper case (`A`-`F`) and in lower case (`a`-`f`).
- R10: Every output pulse appears in the cycle right after the clock edge that accepts the character completing the byte concerned, and the character before it produces no pulse.
- R11: Under synchronous active-low reset all output strobes are low and the parser is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_char` holds a character this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | Data byte write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |
| rec_done | output | 1 | Record finished; a verdict is present |
| chk_ok | output | 1 | Checksum correct |
| chk_err | output | 1 | Checksum wrong |
| fmt_err | output | 1 | Malformed record abandoned |
| unsup_type | output | 1 | Record type other than S1 skipped |

## Verification
The bench targets a count of 3. A design that loses track of the remaining-byte counter would then emit a stray write or never reach the checksum. It also sends a record whose address crosses 0xFFFF, which a design that does not wrap would write past 16 bits or stall on. Non-hex characters are placed both in the address field and after a data write, so a parser that resyncs in the wrong place would report a false verdict or write skipped bytes. The bench also covers a CR in mid-record, a non-S1 record, and `S` characters sent with `in_valid` low. A parser that leaves skip mode too early, or one that samples invalid cycles, would produce writes that the scoreboard does not expect.

// File: rtl/srec_pkg.sv
// Shared definitions for the S1 record parser: parser states and the
// ASCII codes the parser reacts to. Assumes 8-bit ASCII input.
package srec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_COUNT,
        ST_ADDR,
        ST_DATA,
        ST_CHK,
        ST_SKIP
    } srec_state_t;

    localparam logic [7:0] CH_S  = 8'h53;
    localparam logic [7:0] CH_1  = 8'h31;
    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;

    // True for either line terminator.
    function automatic logic is_eol(input logic [7:0] c);
        return (c == CH_CR) || (c == CH_LF);
    endfunction

endpackage

// File: rtl/srec_hex_decode.sv
// Combinational ASCII hex digit decoder. Accepts 0-9, A-F and a-f.
// Any other code gives is_hex = 0 and nibble = 0.
module srec_hex_decode (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nibble
);

    // Map one character to its 4-bit value.
    always_comb begin
        is_hex = 1'b1;
        nibble = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39)      nibble = 4'(ch - 8'h30);
        else if (ch >= 8'h41 && ch <= 8'h46) nibble = 4'(ch - 8'h37);
        else if (ch >= 8'h61 && ch <= 8'h66) nibble = 4'(ch - 8'h57);
        else                                 is_hex = 1'b0;
    end

endmodule

// File: rtl/srec_byte_pair.sv
// Joins two accepted hex nibbles into one byte, high nibble first.
// byte_stb is combinational and is high on the second nibble of a pair.
// clear restarts the pairing and has priority over take.
module srec_byte_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [3:0] nibble,
    output logic       byte_stb,
    output logic [7:0] byte_val
);

    logic       second;
    logic [3:0] hi_nib;

    // Track which half of the pair is due and hold the high nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            second <= 1'b0;
            hi_nib <= 4'h0;
        end else if (take) begin
            second <= ~second;
            if (!second) hi_nib <= nibble;
        end
    end

    assign byte_stb = take && second && !clear;
    assign byte_val = {hi_nib, nibble};

    // R10: a completed byte is always followed by a first nibble, never a second byte.
    p_pairing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

endmodule

// File: rtl/srec_field_seq.sv
// Field sequencer: walks the count, address, data and checksum fields of an
// S1 record, keeps the modulo-256 byte sum and drives the registered
// write and status pulses. Assumes bytes arrive from srec_byte_pair.
module srec_field_seq
    import srec_pkg::*;
#(
    parameter  int ADDR_BYTES = 2,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int AL_W       = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    input  logic              is_hex,
    input  logic              byte_stb,
    input  logic [7:0]        byte_val,
    output logic              in_field,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rec_done,
    output logic              chk_ok,
    output logic              chk_err,
    output logic              fmt_err,
    output logic              unsup_type
);

    localparam logic [7:0] HDR_BYTES = 8'(ADDR_BYTES + 1);

    srec_state_t       state;
    logic [7:0]        sum;
    logic [7:0]        remain;
    logic [AL_W-1:0]   addr_left;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        sum_next;

    assign in_field = (state == ST_COUNT) || (state == ST_ADDR) ||
                      (state == ST_DATA)  || (state == ST_CHK);
    assign sum_next = 8'(sum + byte_val);

    // Main record walk: field order, counters, sum and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sum        <= 8'h00;
            remain     <= 8'h00;
            addr_left  <= '0;
            cur_addr   <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= 8'h00;
            rec_done   <= 1'b0;
            chk_ok     <= 1'b0;
            chk_err    <= 1'b0;
            fmt_err    <= 1'b0;
            unsup_type <= 1'b0;
        end else begin
            wr_en      <= 1'b0;
            rec_done   <= 1'b0;
            chk_ok     <= 1'b0;
            chk_err    <= 1'b0;
            fmt_err    <= 1'b0;
            unsup_type <= 1'b0;
            if (in_valid) begin
                case (state)
                    ST_IDLE: if (in_char == CH_S) state <= ST_TYPE;
                    ST_TYPE: begin
                        if (in_char == CH_1) begin
                            state <= ST_COUNT;
                        end else begin
                            unsup_type <= 1'b1;
                            state      <= is_eol(in_char) ? ST_IDLE : ST_SKIP;
                        end
                    end
                    ST_SKIP: if (is_eol(in_char)) state <= ST_IDLE;
                    default: begin
                        if (!is_hex) begin
                            fmt_err <= 1'b1;
                            state   <= is_eol(in_char) ? ST_IDLE : ST_SKIP;
                        end else if (byte_stb) begin
                            case (state)
                                ST_COUNT: begin
                                    sum <= byte_val;
                                    if (byte_val < HDR_BYTES) begin
                                        fmt_err <= 1'b1;
                                        state   <= ST_SKIP;
                                    end else begin
                                        remain    <= 8'(byte_val - HDR_BYTES);
                                        addr_left <= AL_W'(ADDR_BYTES - 1);
                                        state     <= ST_ADDR;
                                    end
                                end
                                ST_ADDR: begin
                                    sum      <= sum_next;
                                    cur_addr <= ADDR_W'({cur_addr, byte_val});
                                    if (addr_left == '0)
                                        state <= (remain == 8'h00) ? ST_CHK : ST_DATA;
                                    else
                                        addr_left <= addr_left - 1'b1;
                                end
                                ST_DATA: begin
                                    wr_en    <= 1'b1;
                                    wr_addr  <= cur_addr;
                                    wr_data  <= byte_val;
                                    cur_addr <= cur_addr + 1'b1;
                                    sum      <= sum_next;
                                    remain   <= remain - 8'h01;
                                    if (remain == 8'h01) state <= ST_CHK;
                                end
                                default: begin
                                    rec_done <= 1'b1;
                                    chk_ok   <= (sum_next == 8'hFF);
                                    chk_err  <= (sum_next != 8'hFF);
                                    state    <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    // Checker state: address of the previous write in the current record.
    logic              seq_wr;
    logic [ADDR_W-1:0] seq_addr;

    // Remember the last write while a record's data phase is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_wr   <= 1'b0;
            seq_addr <= '0;
        end else if (wr_en) begin
            seq_wr   <= 1'b1;
            seq_addr <= wr_addr;
        end else if (state != ST_DATA && state != ST_CHK) begin
            seq_wr <= 1'b0;
        end
    end

    // R1: writes inside one record step the address by one.
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seq_wr) |-> (wr_addr == seq_addr + 1'b1));

    // R3: every finished record carries exactly one verdict.
    p_done_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> (chk_ok ^ chk_err));

    // R4: a verdict never appears without rec_done.
    p_verdict_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ok || chk_err) |-> rec_done);

    // R6: a write, a verdict, a format error and an unsupported flag never coincide.
    p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rec_done, fmt_err, unsup_type}));

    // R5: while skipping a line, nothing is written or judged in the next cycle.
    p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> (!wr_en && !rec_done));

endmodule

// File: rtl/srec_line_parser.sv
// Top level of the S1 record parser. Decodes hex, pairs nibbles into
// bytes and walks record fields. Writes are issued before the checksum
// verdict; the consumer commits on chk_ok and drops on chk_err.
module srec_line_parser #(
    parameter  int ADDR_BYTES = 2,
    localparam int ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rec_done,
    output logic              chk_ok,
    output logic              chk_err,
    output logic              fmt_err,
    output logic              unsup_type
);

    logic       is_hex;
    logic [3:0] nibble;
    logic       in_field;
    logic       byte_stb;
    logic [7:0] byte_val;

    srec_hex_decode u_hex (
        .ch     (in_char),
        .is_hex (is_hex),
        .nibble (nibble)
    );

    srec_byte_pair u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!in_field),
        .take     (in_valid && is_hex && in_field),
        .nibble   (nibble),
        .byte_stb (byte_stb),
        .byte_val (byte_val)
    );

    srec_field_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_char    (in_char),
        .is_hex     (is_hex),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .in_field   (in_field),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rec_done   (rec_done),
        .chk_ok     (chk_ok),
        .chk_err    (chk_err),
        .fmt_err    (fmt_err),
        .unsup_type (unsup_type)
    );

endmodule

// File: tb/srec_line_parser_test.sv
// Scoreboard bench: driver tasks queue expected events, a monitor pops and
// compares each output event as the parser produces it.
module srec_line_parser_test;

    localparam int K_WR = 0, K_OK = 1, K_ERR = 2, K_FMT = 3, K_UNS = 4, K_BAD = 9;

    typedef struct {
        int          kind;
        logic [15:0] a;
        logic [7:0]  d;
        string       req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        wr_en, rec_done, chk_ok, chk_err, fmt_err, unsup_type;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    ev_t exp_q[$];

    always #4 clk = ~clk;

    srec_line_parser uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rec_done(rec_done), .chk_ok(chk_ok), .chk_err(chk_err),
        .fmt_err(fmt_err), .unsup_type(unsup_type)
    );

    task automatic expect_ev(input int kind, input logic [15:0] a, input logic [7:0] d, input string req);
        ev_t e;
        e.kind = kind; e.a = a; e.d = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic compare(input int kind, input logic [15:0] a, input logic [7:0] d);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1: unexpected event actual kind=%0d addr=%h data=%h expected none", kind, a, d);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || (kind == K_WR && (e.a != a || e.d != d))) begin
                fails++;
                $display("FAIL %s: actual kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                         e.req, kind, a, d, e.kind, e.a, e.d);
            end
        end
    endtask

    // Monitor: sample registered outputs just after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (wr_en)      compare(K_WR, wr_addr, wr_data);
            if (rec_done)   compare((chk_ok && !chk_err) ? K_OK : (chk_err && !chk_ok) ? K_ERR : K_BAD, 16'h0, 8'h0);
            else if (chk_ok || chk_err) compare(K_BAD, 16'h0, 8'h0);
            if (fmt_err)    compare(K_FMT, 16'h0, 8'h0);
            if (unsup_type) compare(K_UNS, 16'h0, 8'h0);
        end
    end

    function automatic string hx(input logic [7:0] b, input bit lower);
        return lower ? $sformatf("%02x", b) : $sformatf("%02X", b);
    endfunction

    // Drive a string, one character per cycle; gaps put an invalid 'S' between characters.
    task automatic send_str(input string s, input bit gaps);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = s[i];
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_char  = 8'h53;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_char  = 8'h00;
    endtask

    // Build an S1 record, queue its expected writes and verdict, then send it.
    task automatic send_s1(input logic [15:0] a, input logic [7:0] d[$], input bit bad,
                           input bit lower, input bit gaps, input string req);
        logic [7:0] cnt, sum, chk;
        string s;
        cnt = 8'(d.size() + 3);
        sum = 8'(cnt + a[15:8] + a[7:0]);
        s = {"S1", hx(cnt, lower), hx(a[15:8], lower), hx(a[7:0], lower)};
        for (int i = 0; i < d.size(); i++) begin
            sum = 8'(sum + d[i]);
            s = {s, hx(d[i], lower)};
            expect_ev(K_WR, 16'(a + 16'(i)), d[i], req);
        end
        chk = ~sum;
        if (bad) chk = chk ^ 8'h01;
        s = {s, hx(chk, lower), "\r\n"};
        expect_ev(bad ? K_ERR : K_OK, 16'h0, 8'h0, bad ? "R4" : "R3");
        send_str(s, gaps);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL R1: watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] none[$];
        repeat (4) @(negedge clk);
        // R11: outputs idle in reset.
        check(!wr_en && !rec_done && !chk_ok && !chk_err && !fmt_err && !unsup_type,
              "R11", "strobes in reset", {wr_en, rec_done, chk_ok, chk_err, fmt_err, unsup_type}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en && !rec_done, "R11", "strobes after reset", {wr_en, rec_done}, 0);

        // R1/R3: the worked example record.
        for (int i = 0; i < 6; i++) begin
            logic [7:0] ex[6] = '{8'h86, 8'h03, 8'h8B, 8'h05, 8'h20, 8'hFE};
            expect_ev(K_WR, 16'h2000 + 16'(i), ex[i], "R1");
        end
        expect_ev(K_OK, 16'h0, 8'h0, "R3");
        send_str("S109200086038B0520FE9F\r\n", 1'b0);

        // R4: corrupted checksum still writes, then reports error.
        send_s1(16'h4100, '{8'h11, 8'h22}, 1'b1, 1'b0, 1'b0, "R4");

        // R2: count of 3 gives no writes and a good verdict.
        none = {};
        send_s1(16'h1234, none, 1'b0, 1'b0, 1'b0, "R2");

        // R9/R1: lower case digits and an address that wraps past 0xFFFF.
        send_s1(16'hFFFE, '{8'hab, 8'hcd, 8'hef}, 1'b0, 1'b1, 1'b0, "R9");

        // R8: junk outside records and invalid cycles carrying 'S'.
        send_str("hello 12\r\n", 1'b0);
        send_s1(16'h0300, '{8'h5A, 8'hA5, 8'h3C}, 1'b0, 1'b0, 1'b1, "R8");

        // R5: a non-S1 record is flagged and skipped.
        expect_ev(K_UNS, 16'h0, 8'h0, "R5");
        send_str("S9030000FC\r\n", 1'b0);
        expect_ev(K_UNS, 16'h0, 8'h0, "R5");
        send_str("S\n", 1'b0);
        send_s1(16'h0500, '{8'h01}, 1'b0, 1'b0, 1'b0, "R5");

        // R6: bad character in the address field.
        expect_ev(K_FMT, 16'h0, 8'h0, "R6");
        send_str("S10520G0S1FF\n", 1'b0);
        // R6: bad character after one data write.
        expect_ev(K_WR, 16'h2000, 8'hAB, "R6");
        expect_ev(K_FMT, 16'h0, 8'h0, "R6");
        send_str("S1052000ABZCD99\n", 1'b0);
        // R6: CR mid-record returns to idle at once.
        expect_ev(K_FMT, 16'h0, 8'h0, "R6");
        send_str("S10510\r", 1'b0);
        send_s1(16'h0600, '{8'h77}, 1'b0, 1'b0, 1'b0, "R6");

        // R7: count below 3.
        expect_ev(K_FMT, 16'h0, 8'h0, "R7");
        send_str("S102FFAAS1\n", 1'b0);
        send_s1(16'h0700, '{8'h42}, 1'b0, 1'b0, 1'b0, "R7");

        // R10: cycle-exact timing of a write strobe.
        expect_ev(K_WR, 16'h1000, 8'hA5, "R10");
        expect_ev(K_OK, 16'h0, 8'h0, "R10");
        send_str("S1041000", 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = "A";
        @(posedge clk);
        #2;
        check(!wr_en, "R10", "wr_en after first nibble", wr_en, 0);
        @(negedge clk);
        in_char = "5";
        @(posedge clk);
        #2;
        check(wr_en && wr_addr == 16'h1000 && wr_data == 8'hA5, "R10", "write after second nibble",
              {wr_en, wr_addr, wr_data}, {1'b1, 16'h1000, 8'hA5});
        send_str("46\r\n", 1'b0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1", "expected events left over", exp_q.size(), 0);
        finish_run();
    end

endmodule